// File: doc/BRIEF.md
# Cable fault isolation sequencer

This block is the digital sequencer inside a branching node of a DC power cable. On every clock it takes one signed sample each of backbone voltage, backbone current and spur current. From these it decides whether the spur switch, the backbone switch, or neither should open after a cable fault. Its outputs are two switch-open commands and a three-bit state code. All of them come from registered state only.

After a fault, the shore station restarts the cable at a low positive level, and the node holds both switches closed. A swing to the low negative level, held for several samples, starts the isolation sequence. The first delay has a fixed length. At its end, any current on the spur shows a spur-side fault, because the load beyond the spur is still unpowered. The second delay is proportional to the measured voltage magnitude. Nodes near a grounded fault see little voltage, so their delay runs out first. When that delay ends, a backbone current that has not fallen opens the backbone switch. The block then holds its decisions until the next positive restart.

The state codes are: 0 idle, 1 armed (positive restart seen), 2 fixed delay, 3 scaled delay, 4 done. One sample LSB is one volt or one current unit.

Top module: `fault_isolation_seq`

## Requirements
- R1: While reset is asserted, and in states 0 and 1, both `spur_open_o` and `bb_open_o` are 0. Reset gives `state_o` = 0.
- R2: The block moves from state 0 or state 4 to state 1 only on a voltage sample >= `POS_TH`. In state 0, negative samples have no effect.
- R3: In state 1, the block enters state 2 after `HOLD_N` consecutive voltage samples <= `NEG_TH`. Any sample above `NEG_TH` restarts the count and leaves the block in state 1.
- R4: State 2 lasts exactly `T2_TICKS` clock cycles.
- R5: In the last state-2 cycle, `spur_open_o` is set exactly when |spur current| > `SPUR_TH`. It stays 0 otherwise.
- R6: State 3 lasts clamp(|v| * `T3_SCALE`, 1, `T3_MAX`) cycles. Here v is the voltage sample in the last state-2 cycle.
- R7: |backbone current| is captured in the last state-2 cycle. `bb_open_o` is set on entry to state 4 unless |backbone current| + `DROP_MARGIN` < captured value in the last state-3 cycle.
- R8: In state 4, both outputs and the state hold whatever the currents do and however negative the voltage goes. A positive restart returns to state 1 with both outputs 0.
- R9: A switch-open command rises only at its decision point: spur on entry to state 3, backbone on entry to state 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| v_bb_i | input | SAMPLE_W | Signed backbone voltage sample |
| i_bb_i | input | SAMPLE_W | Signed backbone current sample |
| i_spur_i | input | SAMPLE_W | Signed spur current sample |
| spur_open_o | output | 1 | 1 commands the spur switch open |
| bb_open_o | output | 1 | 1 commands the backbone switch open |
| state_o | output | 3 | Current sequencer state code |

## Verification
The assertions assume that all three samples are synchronous to the clock and settle before each rising edge. They also assume that the trigger voltage was present on the sample before the state-2 entry. The bench meets both conditions by changing inputs only on falling edges. It holds each level for whole phases and changes the voltage or backbone current only once the state code shows the new phase has begun. Scenario voltages cover the clamp at both ends, and current pairs sit exactly on and just past the spur threshold and the drop margin.

// File: rtl/fis_pkg.sv
package fis_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_T2    = 3'd2,
        ST_T3    = 3'd3,
        ST_DONE  = 3'd4
    } fis_state_e;
endpackage

// File: rtl/fis_trig.sv
module fis_trig #(
    parameter int SAMPLE_W = 12,
    parameter int NEG_TH   = -400,
    parameter int HOLD_N   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_i,
    input  logic signed [SAMPLE_W-1:0] v_i,
    output logic                       trig_o
);
    localparam int HW = $clog2(HOLD_N + 1);
    localparam logic signed [SAMPLE_W-1:0] NEG_LV = SAMPLE_W'(NEG_TH);

    logic [HW-1:0] cnt_d, cnt_q;
    logic          neg;

    always_comb begin
        neg    = (v_i <= NEG_LV);
        cnt_d  = cnt_q;
        if (!en_i || !neg)
            cnt_d = '0;
        else if (cnt_q != HW'(HOLD_N))
            cnt_d = cnt_q + 1'b1;
        trig_o = en_i && neg && (cnt_q == HW'(HOLD_N - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: a trigger needs the current sample to be negative enough
    p_trig_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (v_i <= NEG_LV));
endmodule

// File: rtl/fis_timer.sv
module fis_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i)           cnt_d = val_i;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else                  cnt_d = cnt_q;
        last_o = (cnt_q == CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: an unloaded running count falls by exactly one per cycle
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) != '0 && !$past(load_i)) |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fis_t3len.sv
module fis_t3len #(
    parameter int SAMPLE_W = 12,
    parameter int T3_SCALE = 2,
    parameter int T3_MAX   = 600,
    parameter int CNT_W    = 10
) (
    input  logic signed [SAMPLE_W-1:0] v_i,
    output logic        [CNT_W-1:0]    len_o
);
    localparam int KW = $clog2(T3_SCALE + 1);
    localparam int PW = SAMPLE_W + KW;

    logic [SAMPLE_W-1:0] mag;
    logic [PW-1:0]       prod;
    logic [63:0]         prod64;

    always_comb begin
        mag    = v_i[SAMPLE_W-1] ? (~v_i + 1'b1) : v_i;
        prod   = PW'(mag) * PW'(T3_SCALE);
        prod64 = 64'(prod);
        if (prod64 == 64'd0)             len_o = CNT_W'(1);
        else if (prod64 > 64'(T3_MAX))   len_o = CNT_W'(T3_MAX);
        else                             len_o = CNT_W'(prod);
    end
endmodule

// File: rtl/fault_isolation_seq.sv
module fault_isolation_seq #(
    parameter int SAMPLE_W    = 12,
    parameter int POS_TH      = 400,
    parameter int NEG_TH      = -400,
    parameter int HOLD_N      = 4,
    parameter int T2_TICKS    = 20,
    parameter int T3_SCALE    = 2,
    parameter int T3_MAX      = 600,
    parameter int SPUR_TH     = 50,
    parameter int DROP_MARGIN = 100
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] v_bb_i,
    input  logic signed [SAMPLE_W-1:0] i_bb_i,
    input  logic signed [SAMPLE_W-1:0] i_spur_i,
    output logic                       spur_open_o,
    output logic                       bb_open_o,
    output logic [2:0]                 state_o
);
    import fis_pkg::*;

    localparam int MAXC  = (T2_TICKS > T3_MAX) ? T2_TICKS : T3_MAX;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic signed [SAMPLE_W-1:0] POS_LV = SAMPLE_W'(POS_TH);
    localparam logic signed [SAMPLE_W-1:0] NEG_LV = SAMPLE_W'(NEG_TH);

    typedef struct packed {
        fis_state_e          st;
        logic                spur_open;
        logic                bb_open;
        logic [SAMPLE_W-1:0] i_cap;
    } ctl_t;

    ctl_t             r_d, r_q;
    logic             trig, t_last, t_load;
    logic [CNT_W-1:0] t_val, t3_len;
    logic [SAMPLE_W-1:0] mag_bb, mag_sp;
    logic             pos, spur_fault, dropped;

    function automatic logic [SAMPLE_W-1:0] mag_of(input logic [SAMPLE_W-1:0] x);
        return x[SAMPLE_W-1] ? (~x + 1'b1) : x;
    endfunction

    fis_trig #(.SAMPLE_W(SAMPLE_W), .NEG_TH(NEG_TH), .HOLD_N(HOLD_N)) u_trig (
        .clk(clk), .rst_n(rst_n), .en_i(r_q.st == ST_ARMED), .v_i(v_bb_i), .trig_o(trig)
    );

    fis_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(t_load), .val_i(t_val), .last_o(t_last)
    );

    fis_t3len #(.SAMPLE_W(SAMPLE_W), .T3_SCALE(T3_SCALE), .T3_MAX(T3_MAX), .CNT_W(CNT_W)) u_len (
        .v_i(v_bb_i), .len_o(t3_len)
    );

    always_comb begin
        mag_bb     = mag_of(i_bb_i);
        mag_sp     = mag_of(i_spur_i);
        pos        = (v_bb_i >= POS_LV);
        spur_fault = 32'(mag_sp) > 32'(SPUR_TH);
        dropped    = (32'(mag_bb) + 32'(DROP_MARGIN)) < 32'(r_q.i_cap);
        r_d        = r_q;
        t_load     = 1'b0;
        t_val      = CNT_W'(T2_TICKS);
        case (r_q.st)
            ST_IDLE: if (pos) r_d.st = ST_ARMED;
            ST_ARMED: begin
                r_d.spur_open = 1'b0;
                r_d.bb_open   = 1'b0;
                if (trig) begin
                    r_d.st = ST_T2;
                    t_load = 1'b1;
                end
            end
            ST_T2: if (t_last) begin
                r_d.spur_open = spur_fault;
                r_d.i_cap     = mag_bb;
                t_load        = 1'b1;
                t_val         = t3_len;
                r_d.st        = ST_T3;
            end
            ST_T3: if (t_last) begin
                r_d.bb_open = !dropped;
                r_d.st      = ST_DONE;
            end
            ST_DONE: if (pos) begin
                r_d.st        = ST_ARMED;
                r_d.spur_open = 1'b0;
                r_d.bb_open   = 1'b0;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, spur_open: 1'b0, bb_open: 1'b0, i_cap: '0};
        else        r_q <= r_d;
    end

    assign spur_open_o = r_q.spur_open;
    assign bb_open_o   = r_q.bb_open;
    assign state_o     = r_q.st;

    // R1: switches closed while idle or armed
    p_closed_armed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE || r_q.st == ST_ARMED) |-> (!r_q.spur_open && !r_q.bb_open));
    // R3: the fixed delay starts only after a negative sample
    p_t2_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_T2 && $past(r_q.st) != ST_T2) |-> ($signed($past(v_bb_i)) <= NEG_LV));
    // R6: scaled delay length stays inside its clamp
    p_t3_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (t3_len >= CNT_W'(1)) && (t3_len <= CNT_W'(T3_MAX)));
    // R9 and R5: spur command rises only on entry to the scaled delay
    p_spur_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.spur_open) |-> (r_q.st == ST_T3 && $past(r_q.st) == ST_T2));
    // R9 and R7: backbone command rises only on entry to done
    p_bb_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.bb_open) |-> (r_q.st == ST_DONE && $past(r_q.st) == ST_T3));
    // R8: decisions are held while done
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.st) == ST_DONE && r_q.st == ST_DONE) |-> ($stable(r_q.spur_open) && $stable(r_q.bb_open)));
endmodule

// File: tb/sim_fault_isolation_seq.sv
module sim_fault_isolation_seq;
    localparam int SW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [SW-1:0] v_bb = '0, i_bb = '0, i_sp = '0;
    logic spur_open, bb_open;
    logic [2:0] state;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    typedef struct {
        string name;
        int    sp;
        int    bb;
        int    t2;
        int    t3;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    fault_isolation_seq u0 (
        .clk(clk), .rst_n(rst_n), .v_bb_i(v_bb), .i_bb_i(i_bb), .i_spur_i(i_sp),
        .spur_open_o(spur_open), .bb_open_o(bb_open), .state_o(state)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int iabs(input int x);
        return (x < 0) ? -x : x;
    endfunction

    function automatic int t3_of(input int v);
        int p;
        p = iabs(v) * 2;
        if (p < 1) p = 1;
        if (p > 600) p = 600;
        return p;
    endfunction

    // monitor: measures phase lengths and compares results on entry to done
    int t2c = 0, t3c = 0;
    logic [2:0] prev = 3'd0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (state == 3'd2) t2c++;
            if (state == 3'd3) t3c++;
            if (state == 3'd4 && prev != 3'd4) begin
                if (q.size() == 0) begin
                    chk("R7", "unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk("R4", {e.name, " fixed delay cycles"}, t2c, e.t2);
                    chk("R6", {e.name, " scaled delay cycles"}, t3c, e.t3);
                    chk("R5", {e.name, " spur open"}, int'(spur_open), e.sp);
                    chk("R7", {e.name, " backbone open"}, int'(bb_open), e.bb);
                end
                t2c = 0;
                t3c = 0;
            end
            prev <= state;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_state(input logic [2:0] s);
        do @(negedge clk); while (state != s);
    endtask

    // driver: one complete isolation sequence plus its expected result
    task automatic run_case(input string name, input int vf, input int sp,
                            input int b0, input int b1);
        exp_t e;
        e.name = name;
        e.sp   = (iabs(sp) > 50) ? 1 : 0;
        e.bb   = (iabs(b1) + 100 < iabs(b0)) ? 0 : 1;
        e.t2   = 20;
        e.t3   = t3_of(vf);
        q.push_back(e);
        v_bb = 12'sd500;
        step(3);
        chk("R2", {name, " armed state"}, int'(state), 1);
        v_bb = -12'sd500;
        i_sp = SW'(sp);
        i_bb = SW'(b0);
        wait_state(3'd2);
        v_bb = SW'(vf);
        wait_state(3'd3);
        i_bb = SW'(b1);
        wait_state(3'd4);
        step(1);
    endtask

    initial begin
        step(3);
        chk("R1", "reset state", int'(state), 0);
        chk("R1", "reset spur", int'(spur_open), 0);
        chk("R1", "reset backbone", int'(bb_open), 0);
        rst_n = 1'b1;
        // R2: negative level in idle has no effect
        v_bb = -12'sd500;
        step(10);
        chk("R2", "idle ignores negative", int'(state), 0);
        // R3: hysteresis, a sample at -399 restarts the hold count
        v_bb = 12'sd500;
        step(2);
        v_bb = -12'sd500;
        step(3);
        v_bb = -12'sd399;
        step(1);
        v_bb = -12'sd500;
        step(3);
        chk("R3", "broken hold stays armed", int'(state), 1);
        v_bb = 12'sd0;
        step(2);
        chk("R3", "mid level stays armed", int'(state), 1);
        chk("R1", "armed spur closed", int'(spur_open), 0);

        run_case("spur_fault", -250, 200, 500, 100);
        run_case("near_backbone", -100, 0, 500, 480);
        run_case("far_backbone", -500, 0, 500, 200);
        run_case("no_fault", 0, 10, -300, -50);
        run_case("margin_edge", -30, -51, 500, 400);
        run_case("margin_past", -1, 50, 500, 399);
        run_case("spur_and_bb", -150, 300, 500, 500);

        // R8: done holds through current changes and negative voltage
        i_sp = 12'sd0;
        i_bb = 12'sd0;
        v_bb = -12'sd600;
        step(30);
        chk("R8", "done state held", int'(state), 4);
        chk("R8", "spur held", int'(spur_open), 1);
        chk("R8", "backbone held", int'(bb_open), 1);
        v_bb = 12'sd500;
        step(1);
        chk("R8", "restart armed", int'(state), 1);
        chk("R1", "restart spur closed", int'(spur_open), 0);
        chk("R1", "restart backbone closed", int'(bb_open), 0);
        chk("R4", "all results seen", q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule